// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Overflow Flag

This block is an 8-bit up-counter with a programmable power-of-two prescaler in front of it. The count source is either an instruction-rate enable, produced inside the block by dividing the input clock by four, or an external count pin that is synchronized and edge-detected. Each prescaler output pulse advances the counter by one. When the counter wraps from 255 to 0, a sticky overflow flag is raised and stays up until software clears it.

Software has three write strobes. One loads the count, one loads the control field (source, bypass, ratio) and one clears the flag. Loading the count always discards any partial progress held in the prescaler. Preloading the count with 256 − N makes the next overflow arrive after N counter increments.

The divide-by-four enable is a four-state machine that cycles PH_Q1 → PH_Q2 → PH_Q3 → PH_Q4 → PH_Q1, one state per clock. It issues its tick while in PH_Q4 and restarts in PH_Q1 only on reset. The flag is a two-state machine. It moves FLG_IDLE → FLG_SET on a wrap, stays in FLG_SET while no clear arrives or while a wrap coincides with a clear, and moves FLG_SET → FLG_IDLE on a clear with no wrap in the same cycle.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the count reads 0 and the overflow flag is clear. The control field resets to 0: internal source, prescaler active, ratio 1:2.
- R2: With the internal source and the prescaler bypassed, the counter advances exactly once in every four consecutive clock cycles. Any 40 consecutive cycles after a count write add exactly 10.
- R3: With the external source selected, each rising edge on `ext_cnt_pin` produces one source tick. The tick reaches the counter on the second clock edge after the pin is first sampled high. A level held high counts only once.
- R4: The control word `ctrl_wdata` has this layout. Bit 0 selects the source (1 = external pin, 0 = internal). Bit 1 bypasses the prescaler (1 = ratio 1:1). Bits 4:2 hold a value s that selects ratio 1:2^(s+1), so 0 gives 1:2 and 7 gives 1:256. The counter advances once per 2^(s+1) source ticks.
- R5: A count write loads `cnt_wdata` into the counter on the next clock edge and resets the prescaler's partial count to zero.
- R6: When a count write and a counter increment fall in the same cycle, the written value wins and the overflow flag is not raised in that cycle.
- R7: The flag is set only when an increment takes the count from 255 to 0. A preload of 256 − N raises it after exactly N increments and not before.
- R8: Once set, the flag stays set until `flag_clr` is pulsed. If a wrap occurs in the same cycle as a clear, the flag stays set.
- R9: The source not selected by control bit 0 has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_pin | input | 1 | External count input, asynchronous |
| cnt_we | input | 1 | Count write strobe, one cycle |
| cnt_wdata | input | 8 | Value loaded into the count |
| ctrl_we | input | 1 | Control write strobe, one cycle |
| ctrl_wdata | input | 5 | Control word: [0] source, [1] bypass, [4:2] ratio select |
| flag_clr | input | 1 | Overflow flag clear strobe, one cycle |
| count_o | output | 8 | Current count value |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A prescaler that is not cleared by a count write leaves stale progress behind. It shows at `count_o` as one early increment inside the first prescale period after the write, so it appears within one ratio's worth of source ticks. A divide-by-four phase machine that skips or repeats a state changes the count added over a 40-cycle window. A flag machine that drops FLG_SET without a clear, or enters it without a wrap, shows on `ovf_flag_o` on the very next edge. A wrong priority between write and increment, or between wrap and clear, shows only in the coinciding cycle, so the bench aims strobes at that exact edge.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CNT_W  = 8;
    localparam int SEL_W  = 3;
    localparam int PS_W   = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             bypass;
        logic             src_ext;
    } ptmr_ctrl_t;

    localparam int CTRL_W = $bits(ptmr_ctrl_t);

    typedef enum logic [1:0] {
        PH_Q1,
        PH_Q2,
        PH_Q3,
        PH_Q4
    } ptmr_phase_e;

    typedef enum logic {
        FLG_IDLE,
        FLG_SET
    } ptmr_flag_e;
endpackage

// File: rtl/ptmr_tick_src.sv
module ptmr_tick_src
    import ptmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic src_ext,
    output logic tick_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    ptmr_phase_e phase_q, phase_d;
    logic        inst_tick;
    logic [SH_W-1:0] sync_q;
    logic        ext_tick;

    // state register of the divide-by-four phase machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_Q1;
        else        phase_q <= phase_d;
    end

    // next-state logic
    always_comb begin
        unique case (phase_q)
            PH_Q1: phase_d = PH_Q2;
            PH_Q2: phase_d = PH_Q3;
            PH_Q3: phase_d = PH_Q4;
            PH_Q4: phase_d = PH_Q1;
        endcase
    end

    // output logic
    always_comb begin
        unique case (phase_q)
            PH_Q4:   inst_tick = 1'b1;
            default: inst_tick = 1'b0;
        endcase
    end

    // synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SH_W-2:0], ext_pin};
    end

    assign ext_tick = sync_q[SH_W-2] & ~sync_q[SH_W-1];

    always_comb begin
        if (src_ext) tick_o = ext_tick;
        else         tick_o = inst_tick;
    end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter  int SEL_W = 3,
    localparam int PS_W  = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             clr,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse_o
);
    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] mask;
    logic            hit;

    // terminal mask: bits 0..sel set, so ratio is 2^(sel+1)
    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            mask[i] = (i <= int'(sel));
        end
    end

    assign hit     = ((pre_q & mask) == mask);
    assign pulse_o = src_tick & (bypass | hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || bypass) begin
            pre_q <= '0;
        end else if (src_tick) begin
            if (hit) pre_q <= '0;
            else     pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] count_o,
    output logic         flag_o
);
    logic [W-1:0] cnt_q;
    logic         wrap;
    ptmr_flag_e   flg_q, flg_d;

    // a write wins over an increment in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (we)  cnt_q <= wdata;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign wrap    = inc & ~we & (cnt_q == {W{1'b1}});
    assign count_o = cnt_q;

    // state register of the flag machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= FLG_IDLE;
        else        flg_q <= flg_d;
    end

    // next-state logic: a wrap beats a clear
    always_comb begin
        unique case (flg_q)
            FLG_IDLE: flg_d = wrap ? FLG_SET : FLG_IDLE;
            FLG_SET:  flg_d = (clr && !wrap) ? FLG_IDLE : FLG_SET;
        endcase
    end

    // output logic
    always_comb begin
        unique case (flg_q)
            FLG_SET:  flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_cnt_pin,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_flag_o
);
    ptmr_ctrl_t ctrl_q;
    logic       src_tick;
    logic       ps_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ptmr_ctrl_t'(ctrl_wdata);
    end

    ptmr_tick_src #(.SYNC_STAGES(2)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_pin (ext_cnt_pin),
        .src_ext (ctrl_q.src_ext),
        .tick_o  (src_tick)
    );

    ptmr_prescaler #(.SEL_W(SEL_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .clr      (cnt_we),
        .bypass   (ctrl_q.bypass),
        .sel      (ctrl_q.sel),
        .pulse_o  (ps_pulse)
    );

    ptmr_count #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (ps_pulse),
        .we      (cnt_we),
        .wdata   (cnt_wdata),
        .clr     (flag_clr),
        .count_o (count_o),
        .flag_o  (ovf_flag_o)
    );
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic       flag_clr,
    input logic [7:0] count_o,
    input logic       ovf_flag_o
);
    // R5
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count_o == $past(cnt_wdata));

    // R6
    write_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !ovf_flag_o) |=> !ovf_flag_o);

    // R7
    wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> ($past(count_o) == 8'hFF && count_o == 8'h00));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !flag_clr) |=> ovf_flag_o);

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (count_o == $past(count_o) || count_o == $past(count_o) + 8'd1));
endmodule

bind prescaled_timer prescaled_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .flag_clr   (flag_clr),
    .count_o    (count_o),
    .ovf_flag_o (ovf_flag_o)
);

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_cnt_pin = 1'b0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] count_o;
    logic       ovf_flag_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prescaled_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_cnt_pin(ext_cnt_pin),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .flag_clr   (flag_clr),
        .count_o    (count_o),
        .ovf_flag_o (ovf_flag_o)
    );

    typedef struct packed {
        logic [4:0]  ctrl;
        logic [7:0]  pre;
        logic [10:0] pulses;
        logic [7:0]  exp_cnt;
        logic        exp_flg;
    } vec_t;

    // ctrl = {sel[2:0], bypass, src_ext}; all rows use the external pin
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'b00011, 8'h10, 11'd5,   8'h15, 1'b0},
        '{5'b00001, 8'h00, 11'd7,   8'h03, 1'b0},
        '{5'b01001, 8'hFE, 11'd16,  8'h00, 1'b1},
        '{5'b01101, 8'hFF, 11'd15,  8'hFF, 1'b0},
        '{5'b00011, 8'hFD, 11'd3,   8'h00, 1'b1},
        '{5'b00011, 8'hFD, 11'd2,   8'hFF, 1'b0},
        '{5'b00101, 8'h80, 11'd13,  8'h83, 1'b0},
        '{5'b11101, 8'h00, 11'd512, 8'h02, 1'b0},
        '{5'b11101, 8'hFF, 11'd256, 8'h00, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic clr_flg();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_cnt_pin = 1'b1;
            @(negedge clk);
            @(negedge clk); ext_cnt_pin = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count in reset", count_o, 0);
        chk("R1 flag in reset", ovf_flag_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", count_o, 0);
        chk("R1 flag after reset", ovf_flag_o, 0);

        // vector table: R3 R4 R7
        for (int i = 0; i < NV; i++) begin
            wr_ctrl(VECS[i].ctrl);
            clr_flg();
            wr_cnt(VECS[i].pre);
            pulses(int'(VECS[i].pulses));
            chk($sformatf("R4 vec%0d count", i), count_o, VECS[i].exp_cnt);
            chk($sformatf("R7 vec%0d flag", i), ovf_flag_o, VECS[i].exp_flg);
        end

        // R8 sticky then clear
        repeat (20) @(negedge clk);
        chk("R8 flag held", ovf_flag_o, 1);
        clr_flg();
        chk("R8 flag cleared", ovf_flag_o, 0);

        // R3 level held counts once
        wr_ctrl(5'b00011);
        wr_cnt(8'h00);
        @(negedge clk); ext_cnt_pin = 1'b1;
        repeat (20) @(negedge clk);
        ext_cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 held level", count_o, 1);

        // R9 internal ticks ignored when the pin is selected
        repeat (40) @(negedge clk);
        chk("R9 unselected internal", count_o, 1);

        // R5 count write clears prescaler progress (1:8)
        wr_ctrl(5'b01001);
        wr_cnt(8'h00);
        pulses(5);
        chk("R5 partial prescale", count_o, 0);
        wr_cnt(8'h40);
        chk("R5 load value", count_o, 8'h40);
        pulses(7);
        chk("R5 progress discarded", count_o, 8'h40);
        pulses(1);
        chk("R5 full period after write", count_o, 8'h41);

        // R6 write collides with increment
        wr_ctrl(5'b00011);
        wr_cnt(8'hFF);
        clr_flg();
        @(negedge clk); ext_cnt_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 8'h55;
        @(negedge clk); cnt_we = 1'b0; ext_cnt_pin = 1'b0;
        chk("R6 write wins count", count_o, 8'h55);
        chk("R6 no flag", ovf_flag_o, 0);

        // R8 wrap and clear in the same cycle
        wr_cnt(8'hFF);
        @(negedge clk); ext_cnt_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0; ext_cnt_pin = 1'b0;
        chk("R8 wrap beats clear flag", ovf_flag_o, 1);
        chk("R7 wrap count", count_o, 0);
        clr_flg();

        // R2 internal rate, bypass
        wr_ctrl(5'b00010);
        wr_cnt(8'h20);
        repeat (40) @(negedge clk);
        chk("R2 internal rate", count_o, 8'h2A);

        // R4 internal 1:2
        wr_ctrl(5'b00000);
        wr_cnt(8'h00);
        repeat (80) @(negedge clk);
        chk("R4 internal 1:2", count_o, 8'h0A);

        // R1 reset in mid-run
        wr_ctrl(5'b00011);
        wr_cnt(8'hFF);
        pulses(1);
        chk("R7 flag before reset", ovf_flag_o, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 count cleared", count_o, 0);
        chk("R1 flag cleared", ovf_flag_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule